// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the command layer of a small serial flash slave. An SPI front end hands it received bytes one at a time, a select level that is high while the host holds the device selected, and a pull strobe each time it needs the next byte to shift out. The sequencer decodes the opcode and collects the address and data operands. It streams array data, status or identification bytes back, and runs program and erase operations against an internal synchronous RAM that stands in for the flash array. Each program or erase operation lasts a programmable number of clock cycles. Permission for a write operation comes from an external status and protection unit through `grant_i`. That unit receives write-enable, write-disable and status-write commands, a done pulse, and a pulse that tells it to clear its write-enable latch.

Two state machines do the work. The transaction machine has these states: T_OPC waits for an opcode; T_ADDR collects three address bytes; T_DATA takes one data byte; T_WAIT holds a complete command until deselect; T_READ, T_STAT and T_ID stream output; T_IGNORE discards bytes until deselect. Deselect always returns it to T_OPC. An opcode moves it from T_OPC to T_ADDR, T_DATA, T_WAIT, T_STAT or T_IGNORE. The third address byte moves it from T_ADDR to T_READ, T_ID, T_DATA or T_WAIT. A data byte moves it from T_DATA to T_WAIT, and any extra byte moves it from T_WAIT to T_IGNORE. The execution machine has the states X_IDLE, X_PROG and X_ERASE. A granted write command at deselect moves it from X_IDLE to X_PROG or X_ERASE. It goes back to X_IDLE when the cycle counter expires, and for an erase the fill walk must also have finished.

Top module: `sfc_sequencer`

## Requirements
- R1: After reset, busy_o, aai_o, done_o, wel_clr_o and sr_op_valid are 0 and chk_kind is 0.
- R2: Read (03h, three address bytes) puts the byte at the address on tx_data, and each tx_pull advances to the next address. After the top address (2^AW-1) it continues from 0. Address bits at and above AW are ignored.
- R3: Byte program (02h, three address bytes, one data byte) starts only at deselect, and only with grant_i high. It stores the byte, keeps busy_o high for exactly T_PROG cycles, and then pulses done_o and wel_clr_o for one cycle as busy_o falls.
- R4: Sector erase (20h) sets the 2^SEC_BITS bytes of the aligned region that holds the address to FFh. Block erase (52h) does the same for the aligned 2^BLK_BITS region, and chip erase (60h, no operand) for all bytes. Bytes outside the region are kept. busy_o lasts exactly T_SECT, T_BLOCK or T_CHIP cycles respectively.
- R5: A write command does nothing, and busy_o stays low, when grant_i is low at deselect or when deselect comes before the last operand byte.
- R6: Auto-increment program first takes AFh, three address bytes and a data byte, then in each later transaction AFh and one data byte for the next address. aai_o is high from the first start. A byte that completes below the top address gives done_o without wel_clr_o. The byte at the top address ends the mode: aai_o drops and wel_clr_o pulses with done_o.
- R7: Write disable (04h) ends auto-increment mode (aai_o low), including while a byte is still programming.
- R8: Status read (05h) repeats status_i on tx_data until deselect and is accepted while busy_o is high.
- R9: ID read (90h or ABh, three address bytes) outputs BFh first when A0=0 and 43h first when A0=1. Each tx_pull switches to the other ID byte.
- R10: While busy_o is high every opcode except 05h, and 04h in auto-increment mode, is ignored. While in auto-increment mode without busy, every opcode except AFh, 04h and 05h is ignored.
- R11: At deselect after exactly one opcode byte, 06h gives sr_op_valid with sr_op=1 and 04h gives sr_op=2. 01h with one data byte gives sr_op=3 with that byte on sr_wdata, but only when the previous transaction was exactly 50h.
- R12: While a write command waits for deselect, chk_kind shows 1 for program, 2 for sector, 3 for block and 4 for chip. chk_addr shows the target address: the next address for an auto-increment continuation, and 0 for chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | High while the host keeps the device selected |
| rx_valid | input | 1 | One-cycle strobe, rx_data holds a received byte |
| rx_data | input | 8 | Received byte, opcode or operand |
| tx_pull | input | 1 | Front end has taken tx_data and wants the next byte |
| tx_data | output | 8 | Byte to shift out next |
| status_i | input | 8 | Status byte from the status unit |
| grant_i | input | 1 | Permission for the pending write command |
| chk_kind | output | 3 | Kind of the pending write command for the permission check |
| chk_addr | output | AW | Target address of the pending write command |
| sr_op_valid | output | 1 | One-cycle strobe for a status-unit command |
| sr_op | output | 2 | Status-unit command: 1 enable, 2 disable, 3 status write |
| sr_wdata | output | 8 | Value for a status write |
| busy_o | output | 1 | A program or erase is running |
| aai_o | output | 1 | Auto-increment program mode is active |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| wel_clr_o | output | 1 | One-cycle pulse telling the status unit to clear its write enable |

## Verification
The array contents are tried with directed writes at both ends of the address space followed by a read across the top. This separates a correct wrap from one that stalls or runs past the array, and upper address bytes carry random don't-care bits. Seeded random mixes of programs, reads and grant denials at random addresses compare every byte read against a reference array, which catches a wrong address increment, lost writes and writes that should have been refused. Erases are framed by marker bytes just outside their aligned regions, so an erase range that is off by one or misaligned is seen. The exact length of each busy period tells the timer settings apart. Auto-increment runs into the top address, write-disable and status-write sequences, and opcodes sent while busy show whether the mode flags and the filtering of opcodes follow the rules.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        T_OPC, T_ADDR, T_DATA, T_WAIT, T_READ, T_STAT, T_ID, T_IGNORE
    } txn_state_t;

    typedef enum logic [1:0] {
        X_IDLE, X_PROG, X_ERASE
    } exec_state_t;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_AAI  = 8'hAF;
    localparam logic [7:0] OP_SECT = 8'h20;
    localparam logic [7:0] OP_BLK  = 8'h52;
    localparam logic [7:0] OP_CHIP = 8'h60;
    localparam logic [7:0] OP_STAT = 8'h05;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_ID0  = 8'h90;
    localparam logic [7:0] OP_ID1  = 8'hAB;

    localparam logic [2:0] K_NONE  = 3'd0;
    localparam logic [2:0] K_PROG  = 3'd1;
    localparam logic [2:0] K_SECT  = 3'd2;
    localparam logic [2:0] K_BLOCK = 3'd3;
    localparam logic [2:0] K_CHIP  = 3'd4;

    localparam logic [1:0] SR_WREN = 2'd1;
    localparam logic [1:0] SR_WRDI = 2'd2;
    localparam logic [1:0] SR_WRSR = 2'd3;

endpackage

// File: rtl/sfc_ram.sv
module sfc_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sfc_timer.sv
module sfc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last,
    output logic          idle
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign last = (cnt_q == TW'(1));
    assign idle = (cnt_q == '0);
endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
    import sfc_pkg::*;
#(
    parameter int          AW       = 10,
    parameter int          SEC_BITS = 6,
    parameter int          BLK_BITS = 8,
    parameter int          TW       = 16,
    parameter int          T_PROG   = 6,
    parameter int          T_SECT   = 80,
    parameter int          T_BLOCK  = 300,
    parameter int          T_CHIP   = 1100,
    parameter logic [7:0]  MFR_ID   = 8'hBF,
    parameter logic [7:0]  DEV_ID   = 8'h43
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_pull,
    output logic [7:0]    tx_data,
    input  logic [7:0]    status_i,
    input  logic          grant_i,
    output logic [2:0]    chk_kind,
    output logic [AW-1:0] chk_addr,
    output logic          sr_op_valid,
    output logic [1:0]    sr_op,
    output logic [7:0]    sr_wdata,
    output logic          busy_o,
    output logic          aai_o,
    output logic          done_o,
    output logic          wel_clr_o
);
    localparam logic [AW:0]   SEC_LEN  = (AW+1)'(1) << SEC_BITS;
    localparam logic [AW:0]   BLK_LEN  = (AW+1)'(1) << BLK_BITS;
    localparam logic [AW:0]   CHIP_LEN = (AW+1)'(1) << AW;
    localparam logic [AW-1:0] SEC_MASK = AW'((1 << SEC_BITS) - 1);
    localparam logic [AW-1:0] BLK_MASK = AW'((1 << BLK_BITS) - 1);
    localparam logic [AW-1:0] TOP_ADDR = '1;

    txn_state_t  txn_q, txn_d;
    exec_state_t xst_q, xst_d;

    logic [7:0]    opc_q;
    logic [1:0]    abyte_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          sel_d;
    logic [AW-1:0] rd_ptr;
    logic          id_hi;
    logic          ewsr_armed;
    logic          aai_q;
    logic [AW-1:0] aai_addr;
    logic          x_aai;
    logic [AW-1:0] wptr;
    logic [AW:0]   wcnt;
    logic [AW:0]   wlen;

    logic          busy;
    logic          fall;
    logic          launch;
    logic          walk_done;
    logic          exec_end;
    logic [2:0]    pend_kind;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] erase_base;
    logic [AW:0]   erase_len;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;
    logic          tmr_idle;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_q;
    txn_state_t    opc_route;

    assign busy      = (xst_q != X_IDLE);
    assign fall      = sel_d && !sel;
    assign walk_done = (wcnt == wlen);

    // kind and target of the command held in T_WAIT
    always_comb begin
        case (opc_q)
            OP_PROG, OP_AAI: pend_kind = K_PROG;
            OP_SECT:         pend_kind = K_SECT;
            OP_BLK:          pend_kind = K_BLOCK;
            OP_CHIP:         pend_kind = K_CHIP;
            default:         pend_kind = K_NONE;
        endcase
        if (pend_kind == K_CHIP) begin
            tgt_addr = '0;
        end else if (opc_q == OP_AAI && aai_q) begin
            tgt_addr = aai_addr + AW'(1);
        end else begin
            tgt_addr = addr_q;
        end
        case (pend_kind)
            K_SECT: begin
                erase_base = tgt_addr & ~SEC_MASK;
                erase_len  = SEC_LEN;
                tmr_val    = TW'(T_SECT);
            end
            K_BLOCK: begin
                erase_base = tgt_addr & ~BLK_MASK;
                erase_len  = BLK_LEN;
                tmr_val    = TW'(T_BLOCK);
            end
            K_CHIP: begin
                erase_base = '0;
                erase_len  = CHIP_LEN;
                tmr_val    = TW'(T_CHIP);
            end
            default: begin
                erase_base = tgt_addr;
                erase_len  = '0;
                tmr_val    = TW'(T_PROG);
            end
        endcase
    end

    assign launch = fall && (txn_q == T_WAIT) && (pend_kind != K_NONE)
                    && grant_i && !busy;
    assign exec_end = ((xst_q == X_PROG) && tmr_last)
                   || ((xst_q == X_ERASE) && (tmr_last || tmr_idle) && walk_done);

    // opcode filter: busy, auto-increment mode, normal
    always_comb begin
        if (rx_data == OP_STAT) begin
            opc_route = T_STAT;
        end else if (busy) begin
            opc_route = (rx_data == OP_WRDI && aai_q) ? T_WAIT : T_IGNORE;
        end else if (aai_q) begin
            if (rx_data == OP_AAI)       opc_route = T_DATA;
            else if (rx_data == OP_WRDI) opc_route = T_WAIT;
            else                         opc_route = T_IGNORE;
        end else begin
            case (rx_data)
                OP_READ, OP_PROG, OP_AAI, OP_SECT,
                OP_BLK, OP_ID0, OP_ID1:            opc_route = T_ADDR;
                OP_CHIP, OP_WREN, OP_WRDI, OP_EWSR: opc_route = T_WAIT;
                OP_WRSR:                            opc_route = T_DATA;
                default:                            opc_route = T_IGNORE;
            endcase
        end
    end

    // transaction next state
    always_comb begin
        txn_d = txn_q;
        if (!sel) begin
            txn_d = T_OPC;
        end else if (rx_valid) begin
            unique case (txn_q)
                T_OPC:  txn_d = opc_route;
                T_ADDR: begin
                    if (abyte_q == 2'd2) begin
                        if (opc_q == OP_READ)                         txn_d = T_READ;
                        else if (opc_q == OP_ID0 || opc_q == OP_ID1)  txn_d = T_ID;
                        else if (opc_q == OP_PROG || opc_q == OP_AAI) txn_d = T_DATA;
                        else                                          txn_d = T_WAIT;
                    end
                end
                T_DATA:   txn_d = T_WAIT;
                T_WAIT:   txn_d = T_IGNORE;
                T_READ:   txn_d = T_READ;
                T_STAT:   txn_d = T_STAT;
                T_ID:     txn_d = T_ID;
                T_IGNORE: txn_d = T_IGNORE;
            endcase
        end
    end

    // execution next state
    always_comb begin
        xst_d = xst_q;
        unique case (xst_q)
            X_IDLE:  if (launch) xst_d = (pend_kind == K_PROG) ? X_PROG : X_ERASE;
            X_PROG:  if (exec_end) xst_d = X_IDLE;
            X_ERASE: if (exec_end) xst_d = X_IDLE;
            default: xst_d = X_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_q <= T_OPC;
            xst_q <= X_IDLE;
        end else begin
            txn_q <= txn_d;
            xst_q <= xst_d;
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q       <= '0;
            abyte_q     <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            sel_d       <= 1'b0;
            rd_ptr      <= '0;
            id_hi       <= 1'b0;
            ewsr_armed  <= 1'b0;
            aai_q       <= 1'b0;
            aai_addr    <= '0;
            x_aai       <= 1'b0;
            wptr        <= '0;
            wcnt        <= '0;
            wlen        <= '0;
            done_o      <= 1'b0;
            wel_clr_o   <= 1'b0;
            sr_op_valid <= 1'b0;
            sr_op       <= '0;
            sr_wdata    <= '0;
        end else begin
            sel_d       <= sel;
            done_o      <= 1'b0;
            wel_clr_o   <= 1'b0;
            sr_op_valid <= 1'b0;

            if (sel && rx_valid) begin
                case (txn_q)
                    T_OPC: begin
                        opc_q   <= rx_data;
                        abyte_q <= '0;
                    end
                    T_ADDR: begin
                        addr_q  <= AW'({addr_q, rx_data});
                        abyte_q <= abyte_q + 2'd1;
                        if (abyte_q == 2'd2) begin
                            rd_ptr <= AW'({addr_q, rx_data});
                            id_hi  <= rx_data[0];
                        end
                    end
                    T_DATA:  data_q <= rx_data;
                    default: ;
                endcase
            end

            if (sel && tx_pull) begin
                if (txn_q == T_READ) rd_ptr <= rd_ptr + AW'(1);
                if (txn_q == T_ID)   id_hi  <= ~id_hi;
            end

            if (fall) begin
                ewsr_armed <= (txn_q == T_WAIT) && (opc_q == OP_EWSR);
                if (txn_q == T_WAIT) begin
                    case (opc_q)
                        OP_WREN: begin
                            sr_op_valid <= 1'b1;
                            sr_op       <= SR_WREN;
                        end
                        OP_WRDI: begin
                            sr_op_valid <= 1'b1;
                            sr_op       <= SR_WRDI;
                            aai_q       <= 1'b0;
                        end
                        OP_WRSR: begin
                            if (ewsr_armed) begin
                                sr_op_valid <= 1'b1;
                                sr_op       <= SR_WRSR;
                                sr_wdata    <= data_q;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            if (launch) begin
                x_aai <= (opc_q == OP_AAI);
                wptr  <= erase_base;
                wcnt  <= '0;
                wlen  <= erase_len;
                if (opc_q == OP_AAI) begin
                    aai_q    <= 1'b1;
                    aai_addr <= tgt_addr;
                end
            end

            if (xst_q == X_ERASE && !walk_done) begin
                wptr <= wptr + AW'(1);
                wcnt <= wcnt + (AW+1)'(1);
            end

            if (exec_end) begin
                done_o    <= 1'b1;
                wel_clr_o <= !x_aai || (aai_addr == TOP_ADDR);
                if (x_aai && aai_addr == TOP_ADDR) aai_q <= 1'b0;
            end
        end
    end

    // combinational outputs
    always_comb begin
        unique case (txn_q)
            T_READ:  tx_data = ram_q;
            T_STAT:  tx_data = status_i;
            T_ID:    tx_data = id_hi ? DEV_ID : MFR_ID;
            default: tx_data = 8'h00;
        endcase
        chk_kind  = (txn_q == T_WAIT) ? pend_kind : K_NONE;
        chk_addr  = tgt_addr;
        busy_o    = busy;
        aai_o     = aai_q;
        ram_we    = (launch && pend_kind == K_PROG) || (xst_q == X_ERASE && !walk_done);
        ram_waddr = launch ? tgt_addr : wptr;
        ram_wdata = launch ? data_q : 8'hFF;
    end

    sfc_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (tmr_val),
        .last     (tmr_last),
        .idle     (tmr_idle)
    );

    sfc_ram #(.AW(AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_ptr),
        .rdata (ram_q)
    );
endmodule

// File: rtl/sfc_sequencer_chk.sv
module sfc_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       busy_o,
    input logic       aai_o,
    input logic       done_o,
    input logic       wel_clr_o,
    input logic       sr_op_valid,
    input logic [1:0] sr_op
);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R5
    start_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(sel));

    // R6
    welclr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> done_o);

    // R11
    srop_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_op_valid |-> ((sr_op != 2'd0) && !$past(sel)));

    // R7
    aai_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aai_o) |-> (done_o || (sr_op_valid && sr_op == 2'd2)));
endmodule

bind sfc_sequencer sfc_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .busy_o      (busy_o),
    .aai_o       (aai_o),
    .done_o      (done_o),
    .wel_clr_o   (wel_clr_o),
    .sr_op_valid (sr_op_valid),
    .sr_op       (sr_op)
);

// File: tb/sfc_sequencer_test.sv
`timescale 1ns/1ps
module sfc_sequencer_test;
    localparam int AW      = 10;
    localparam int DEPTH   = 1 << AW;
    localparam int T_PROG  = 6;
    localparam int T_SECT  = 80;
    localparam int T_BLOCK = 300;
    localparam int T_CHIP  = 1100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          tx_pull = 1'b0;
    logic [7:0]    tx_data;
    logic [7:0]    status_i = 8'h8C;
    logic          grant_i = 1'b1;
    logic [2:0]    chk_kind;
    logic [AW-1:0] chk_addr;
    logic          sr_op_valid;
    logic [1:0]    sr_op;
    logic [7:0]    sr_wdata;
    logic          busy_o, aai_o, done_o, wel_clr_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] mdl [0:DEPTH-1];

    always #2.5 clk = ~clk;

    sfc_sequencer #(
        .AW(AW), .SEC_BITS(6), .BLK_BITS(8), .TW(16),
        .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLOCK(T_BLOCK), .T_CHIP(T_CHIP),
        .MFR_ID(8'hBF), .DEV_ID(8'h43)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_pull(tx_pull), .tx_data(tx_data), .status_i(status_i), .grant_i(grant_i),
        .chk_kind(chk_kind), .chk_addr(chk_addr), .sr_op_valid(sr_op_valid),
        .sr_op(sr_op), .sr_wdata(sr_wdata), .busy_o(busy_o), .aai_o(aai_o),
        .done_o(done_o), .wel_clr_o(wel_clr_o)
    );

    function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a, input int bits);
        return a & ~AW'((1 << bits) - 1);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic t_begin();
        @(negedge clk); sel = 1'b1;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic put_addr(input logic [AW-1:0] a);
        logic [23:0] full;
        full = {14'($urandom), a};
        put(full[23:16]); put(full[15:8]); put(full[7:0]);
    endtask

    task automatic t_end();
        @(negedge clk); sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic pull();
        @(negedge clk); tx_pull = 1'b1;
        @(negedge clk); tx_pull = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input int cnt);
        t_begin(); put(8'h03); put_addr(a);
        @(negedge clk);
        for (int i = 0; i < cnt; i++) begin
            check(tag, tx_data, mdl[AW'(a + AW'(i))]);
            pull();
        end
        t_end();
    endtask

    task automatic prog(input string tag, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic g);
        int n;
        t_begin(); put(8'h02); put_addr(a); put(d);
        check({tag, " R12 kind"}, chk_kind, 1);
        check({tag, " R12 addr"}, chk_addr, a);
        grant_i = g;
        t_end();
        wait_idle(n);
        if (g) begin
            check({tag, " R3 busy cycles"}, n, T_PROG);
            check({tag, " R3 done"}, done_o, 1);
            check({tag, " R3 wel_clr"}, wel_clr_o, 1);
            mdl[a] = d;
        end else begin
            check({tag, " R5 denied busy"}, n, 0);
        end
        grant_i = 1'b1;
    endtask

    task automatic erase(input string tag, input logic [7:0] op, input logic [AW-1:0] a);
        int n, bits, tcyc, kind;
        logic [AW-1:0] b;
        case (op)
            8'h20:   begin bits = 6;  tcyc = T_SECT;  kind = 2; end
            8'h52:   begin bits = 8;  tcyc = T_BLOCK; kind = 3; end
            default: begin bits = AW; tcyc = T_CHIP;  kind = 4; end
        endcase
        t_begin(); put(op);
        if (op != 8'h60) put_addr(a);
        check({tag, " R12 kind"}, chk_kind, kind);
        check({tag, " R12 addr"}, chk_addr, (op == 8'h60) ? 0 : int'(a));
        t_end();
        wait_idle(n);
        check({tag, " R4 busy cycles"}, n, tcyc);
        check({tag, " R4 done"}, done_o, 1);
        b = (bits == AW) ? '0 : base_of(a, bits);
        for (int i = 0; i < (1 << bits); i++) mdl[AW'(b + AW'(i))] = 8'hFF;
    endtask

    task automatic aai_step(input string tag, input logic first, input logic [AW-1:0] a,
                            input logic [7:0] d, input logic last_exp);
        int n;
        t_begin(); put(8'hAF);
        if (first) put_addr(a);
        put(d);
        check({tag, " R12 kind"}, chk_kind, 1);
        check({tag, " R12 addr"}, chk_addr, a);
        t_end();
        wait_idle(n);
        check({tag, " R6 busy cycles"}, n, T_PROG);
        check({tag, " R6 done"}, done_o, 1);
        check({tag, " R6 wel_clr"}, wel_clr_o, last_exp);
        check({tag, " R6 aai flag"}, aai_o, !last_exp);
        mdl[a] = d;
    endtask

    task automatic one_byte(input logic [7:0] op);
        t_begin(); put(op); t_end();
    endtask

    initial begin
        int n;
        logic [AW-1:0] a;
        logic [7:0] d;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 aai", aai_o, 0);
        check("R1 done", done_o, 0);
        check("R1 wel_clr", wel_clr_o, 0);
        check("R1 sr_op_valid", sr_op_valid, 0);
        check("R1 chk_kind", chk_kind, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R11 write enable and disable forwarding
        one_byte(8'h06);
        check("R11 wren valid", sr_op_valid, 1);
        check("R11 wren code", sr_op, 1);
        @(negedge clk);
        check("R11 pulse", sr_op_valid, 0);
        one_byte(8'h04);
        check("R11 wrdi code", sr_op, 2);

        // R4 chip erase establishes a known array
        erase("chip", 8'h60, '0);
        read_chk("R4 chip", AW'(517), 4);

        // R2 wrap at the top
        prog("top", TOP(), 8'h5A, 1'b1);
        prog("zero", '0, 8'hC3, 1'b1);
        read_chk("R2 wrap", AW'(DEPTH - 2), 4);

        // R3 R5 random programs and reads
        for (int i = 0; i < 30; i++) begin
            a = AW'($urandom);
            d = 8'($urandom);
            if ($urandom % 3 != 0) prog("R3 rnd", a, d, ($urandom % 5) != 0);
            else read_chk("R2 rnd", a, 3);
        end

        // R5 truncated program
        a = AW'(300);
        t_begin(); put(8'h02); put_addr(a); t_end();
        wait_idle(n);
        check("R5 truncated busy", n, 0);
        read_chk("R5 truncated mem", a, 1);

        // R4 sector erase framed by markers
        a = AW'(200);
        prog("mk0", base_of(a, 6) - AW'(1), 8'h11, 1'b1);
        prog("mk1", base_of(a, 6) + AW'(64), 8'h22, 1'b1);
        prog("in", a, 8'h33, 1'b1);
        erase("sect", 8'h20, a);
        read_chk("R4 sector", base_of(a, 6) - AW'(1), 66);

        // R4 block erase framed by markers
        a = AW'(600);
        prog("mk2", base_of(a, 8) - AW'(1), 8'h44, 1'b1);
        prog("mk3", base_of(a, 8) + AW'(256), 8'h55, 1'b1);
        prog("in2", a, 8'h66, 1'b1);
        erase("block", 8'h52, a);
        read_chk("R4 block lo", base_of(a, 8) - AW'(1), 3);
        read_chk("R4 block hi", base_of(a, 8) + AW'(254), 3);

        // R8 R10 status and ignored command while busy
        t_begin(); put(8'h52); put_addr(AW'(10)); t_end();
        check("R10 erase busy", busy_o, 1);
        t_begin(); put(8'h05); @(negedge clk);
        check("R8 status busy", tx_data, 8'h8C);
        status_i = 8'h03;
        pull();
        check("R8 status repeat", tx_data, 8'h03);
        t_end();
        status_i = 8'h8C;
        t_begin(); put(8'h02); put_addr(AW'(900)); put(8'h77); t_end();
        wait_idle(n);
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        check("R10 no restart", busy_o, 0);
        read_chk("R10 ignored prog", AW'(900), 1);
        read_chk("R10 erased", AW'(10), 2);

        // R6 auto-increment into the top address
        aai_step("aai0", 1'b1, AW'(DEPTH - 3), 8'hA1, 1'b0);
        t_begin(); put(8'h02); put_addr(AW'(5)); put(8'h99); t_end();
        wait_idle(n);
        check("R10 prog in aai", n, 0);
        aai_step("aai1", 1'b0, AW'(DEPTH - 2), 8'hA2, 1'b0);
        aai_step("aai2", 1'b0, AW'(DEPTH - 1), 8'hA3, 1'b1);
        read_chk("R6 readback", AW'(DEPTH - 3), 4);

        // R7 write disable ends auto-increment, also while busy
        aai_step("aai3", 1'b1, AW'(256), 8'hB1, 1'b0);
        one_byte(8'h04);
        check("R7 aai off", aai_o, 0);
        check("R7 wrdi forwarded", sr_op, 2);
        t_begin(); put(8'hAF); put(8'hB2); t_end();
        wait_idle(n);
        check("R7 no continuation", n, 0);
        read_chk("R7 mem", AW'(257), 1);
        t_begin(); put(8'hAF); put_addr(AW'(400)); put(8'hC1); t_end();
        mdl[400] = 8'hC1;
        one_byte(8'h04);
        check("R7 aai off busy", aai_o, 0);
        wait_idle(n);
        check("R7 done wel_clr", wel_clr_o, 0);

        // R11 status write sequencing
        one_byte(8'h50);
        t_begin(); put(8'h01); put(8'h55); t_end();
        check("R11 wrsr valid", sr_op_valid, 1);
        check("R11 wrsr code", sr_op, 3);
        check("R11 wrsr data", sr_wdata, 8'h55);
        t_begin(); put(8'h01); put(8'hAA); t_end();
        check("R11 wrsr unarmed", sr_op_valid, 0);
        one_byte(8'h50);
        one_byte(8'h06);
        t_begin(); put(8'h01); put(8'hAA); t_end();
        check("R11 wrsr stale", sr_op_valid, 0);

        // R9 identification
        t_begin(); put(8'h90); put(8'h00); put(8'h00); put(8'h00); @(negedge clk);
        check("R9 a0=0 first", tx_data, 8'hBF);
        pull(); check("R9 a0=0 second", tx_data, 8'h43);
        pull(); check("R9 a0=0 third", tx_data, 8'hBF);
        t_end();
        t_begin(); put(8'hAB); put(8'h00); put(8'h00); put(8'h01); @(negedge clk);
        check("R9 a0=1 first", tx_data, 8'h43);
        pull(); check("R9 a0=1 second", tx_data, 8'hBF);
        t_end();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [AW-1:0] TOP();
        return AW'(DEPTH - 1);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule